// File: doc/BRIEF.md
# TDM Multiplex Time-Slot Access Port

This block attaches a device whose internal frame has 32 time slots of 8 bits each to a local serial highway. The highway can run at one, two or four times the internal rate, so one frame carries 32, 64 or 128 external slots. A rising edge on the frame-sync input aligns an internal bit counter to the highway. A configuration input can shift that alignment by one bit period. A second configuration input gives a bit clock at either the data rate or twice the data rate.

When the multiplex factor is k, internal slot n sits in external slot k·n + offset. The offset is selectable and only its low log2(k) bits count. During the selected external slots the block reads the serial input into bytes. It presents each byte with a one-cycle strobe and its internal slot number. In the same slots it drives the transmit byte out MSB first. It asks for that byte through a request/slot-number pair. In every other slot the output enable is low.

Top module: `tdm_slot_port`

## Requirements
- R1: `cfg_rate` picks the multiplex factor k: 0 gives k=1, 1 gives k=2, and 2 or 3 give k=4. A frame is 256·k bits. External slot e = bit index / 8 is selected when e mod k equals the offset, and it carries internal slot e / k. For example, with k=4 and offset 2, internal slot 3 lives in external slot 14.
- R2: Only the low log2(k) bits of `cfg_offset` are used. At k=1 both bits are ignored. At k=2 bit 1 is ignored.
- R3: With `cfg_dly`=0, the clock cycle (or first cycle of the bit period) in which `fsync` is first seen high carries bit 0 of external slot 0. With `cfg_dly`=1, that cycle carries the last bit of the frame, and bit 0 follows one bit period later.
- R4: With `cfg_dbl`=1, each bit lasts two clock cycles, starting at the cycle that holds the sync edge. `din` is sampled in the second cycle of each bit. `dout` and `dout_oe` change only at the first cycle of each bit.
- R5: `dout_oe` is 1 exactly during the bits of selected slots. There, `dout` carries the transmit byte MSB first (bit 7 in bit position 0 of the slot). Everywhere else `dout` is 0.
- R6: The cycle after the last bit of a selected slot is sampled, `rx_valid` is high for one cycle. At the same time `rx_byte` holds the 8 sampled bits (the first sampled bit in bit 7), and `rx_slot` holds the internal slot number.
- R7: `tx_req` is high in the cycle before each output bit of a selected slot. With it, `tx_slot` gives that slot's internal number. `tx_data` must then hold that slot's byte, and the block reads the bit it needs.
- R8: After reset and before the first `fsync` rising edge, `dout_oe`, `dout`, `tx_req` and `rx_valid` all stay 0.
- R9: Every rising edge of `fsync` realigns the counter, even one that comes at a time other than the frame boundary.
- R10: Without a sync edge, the counter wraps at the end of the frame and keeps the same slot timing through the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync; its rising edge aligns the frame |
| din | input | 1 | Serial receive data from the highway |
| cfg_rate | input | 2 | Multiplex factor select (0: x1, 1: x2, 2/3: x4) |
| cfg_offset | input | 2 | Sub-slot position within each group of k external slots |
| cfg_dbl | input | 1 | 1: clock runs at twice the data rate |
| cfg_dly | input | 1 | 1: sync edge marks the bit before frame bit 0 |
| tx_data | input | 8 | Transmit byte for the slot named by tx_slot |
| tx_req | output | 1 | Next cycle drives a bit of a selected slot |
| tx_slot | output | 5 | Internal slot number of that bit |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Output enable for dout (low means high impedance) |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Received byte |
| rx_slot | output | 5 | Internal slot number of the received byte |

## Verification
The hardest cases to reach from the ports are those where the counter is not simply free-running in step with the frame. These are a sync edge that lands mid-frame, a missing sync pulse, and the one-bit delayed alignment combined with the doubled clock, where the edge cycle belongs to the last bit of the previous frame. The stimulus runs separate configurations with a reset between them. It drops one sync pulse in one run and adds a sync pulse at an odd cycle in another. A timeline model in the bench counts cycles since the last edge and derives the bit index and phase for each cycle. The bench drives `din` from the external slot number, so every received byte reveals which external slot it came from.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int unsigned INT_SLOTS = 32;
    localparam int unsigned SLOT_W    = 8;
    localparam int unsigned MAX_MUX   = 4;

    localparam int unsigned NSLOT_W   = $clog2(INT_SLOTS);
    localparam int unsigned BIT_W     = $clog2(SLOT_W);
    localparam int unsigned EXT_W     = $clog2(INT_SLOTS * MAX_MUX);
    localparam int unsigned POS_W     = EXT_W + BIT_W;
    localparam int unsigned BASE_BITS = INT_SLOTS * SLOT_W;

    typedef logic [POS_W-1:0]   pos_t;
    typedef logic [NSLOT_W-1:0] islot_t;
    typedef logic [BIT_W-1:0]   bitn_t;
    typedef logic [SLOT_W-1:0]  sbyte_t;

    // log2 of the multiplex factor; codes 2 and 3 both mean x4
    function automatic logic [1:0] mux_log(input logic [1:0] rate);
        case (rate)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fsync,
    input  logic [1:0] cfg_rate,
    input  logic       cfg_dbl,
    input  logic       cfg_dly,
    output pos_t       cur_pos,
    output logic       cur_lock,
    output logic       sample_en,
    output pos_t       nxt_pos,
    output logic       nxt_lock
);

    typedef struct packed {
        logic fs;
        logic ph;
        logic lock;
        pos_t pos;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic edge_s;
    logic step_s;
    pos_t last_s;
    logic [POS_W:0] span_s;

    always_comb begin
        span_s = (POS_W+1)'(BASE_BITS) << mux_log(cfg_rate);
        last_s = pos_t'(span_s - 1'b1);
        edge_s = fsync & ~tmr_q.fs;
        step_s = ~cfg_dbl | tmr_q.ph;

        tmr_d    = tmr_q;
        tmr_d.fs = fsync;
        if (edge_s) begin
            tmr_d.lock = 1'b1;
            case ({cfg_dly, cfg_dbl})
                2'b00: begin tmr_d.pos = pos_t'(1); tmr_d.ph = 1'b0; end
                2'b01: begin tmr_d.pos = '0;        tmr_d.ph = 1'b1; end
                2'b10: begin tmr_d.pos = '0;        tmr_d.ph = 1'b0; end
                default: begin tmr_d.pos = last_s;  tmr_d.ph = 1'b1; end
            endcase
        end else if (step_s) begin
            tmr_d.ph  = 1'b0;
            tmr_d.pos = (tmr_q.pos >= last_s) ? '0 : tmr_q.pos + 1'b1;
        end else begin
            tmr_d.ph  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '{fs: 1'b1, ph: 1'b0, lock: 1'b0, pos: '0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign cur_pos   = tmr_q.pos;
    assign cur_lock  = tmr_q.lock;
    assign sample_en = step_s;
    assign nxt_pos   = tmr_d.pos;
    assign nxt_lock  = tmr_d.lock;

    // R4: in doubled-clock mode a first-phase cycle is followed by a second-phase cycle
    assert_phase_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dbl && $stable(cfg_dbl) && !tmr_q.ph && !(fsync && !tmr_q.fs)) |=> tmr_q.ph);

    // R10: counter wraps to bit 0 after the last bit of the frame
    assert_frame_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.pos == last_s && sample_en && !(fsync && !tmr_q.fs) && $stable(cfg_rate))
        |=> (tmr_q.pos == '0));

endmodule

// File: rtl/tdm_slot_map.sv
module tdm_slot_map
    import tdm_pkg::*;
(
    input  pos_t       pos,
    input  logic [1:0] cfg_rate,
    input  logic [1:0] cfg_offset,
    output logic       sel,
    output islot_t     islot,
    output bitn_t      bitn
);

    logic [EXT_W-1:0] ext_s;

    always_comb begin
        ext_s = pos[POS_W-1:BIT_W];
        bitn  = pos[BIT_W-1:0];
        case (mux_log(cfg_rate))
            2'd0: begin
                sel   = 1'b1;
                islot = ext_s[NSLOT_W-1:0];
            end
            2'd1: begin
                sel   = (ext_s[0] == cfg_offset[0]);
                islot = ext_s[NSLOT_W:1];
            end
            default: begin
                sel   = (ext_s[1:0] == cfg_offset);
                islot = ext_s[NSLOT_W+1:2];
            end
        endcase
    end

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
    import tdm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cur_lock,
    input  logic   sample_en,
    input  logic   csel,
    input  islot_t cislot,
    input  bitn_t  cbit,
    input  logic   din,
    output logic   rx_valid,
    output sbyte_t rx_byte,
    output islot_t rx_slot
);

    typedef struct packed {
        sbyte_t sh;
        logic   v;
        sbyte_t rbyte;
        islot_t slot;
    } rx_t;

    rx_t rx_d, rx_q;
    sbyte_t shifted_s;

    always_comb begin
        shifted_s = {rx_q.sh[SLOT_W-2:0], din};
        rx_d      = rx_q;
        rx_d.v    = 1'b0;
        if (cur_lock && sample_en && csel) begin
            rx_d.sh = shifted_s;
            if (cbit == bitn_t'(SLOT_W-1)) begin
                rx_d.v     = 1'b1;
                rx_d.rbyte = shifted_s;
                rx_d.slot  = cislot;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign rx_valid = rx_q.v;
    assign rx_byte  = rx_q.rbyte;
    assign rx_slot  = rx_q.slot;

    // R6: a received-byte strobe lasts exactly one cycle
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser
    import tdm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   nxt_lock,
    input  logic   nsel,
    input  islot_t nislot,
    input  bitn_t  nbit,
    input  sbyte_t tx_data,
    output logic   tx_req,
    output islot_t tx_slot,
    output logic   dout,
    output logic   dout_oe
);

    typedef struct packed {
        logic oe;
        logic d;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_req  = nxt_lock & nsel;
        tx_slot = nislot;
        tx_d.oe = tx_req;
        tx_d.d  = tx_req & tx_data[bitn_t'(SLOT_W-1) - nbit];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign dout    = tx_q.d;
    assign dout_oe = tx_q.oe;

    // R5: the data line rests at 0 while not enabled
    assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !dout);

endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
    import tdm_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fsync,
    input  logic         din,
    input  logic [1:0]   cfg_rate,
    input  logic [1:0]   cfg_offset,
    input  logic         cfg_dbl,
    input  logic         cfg_dly,
    input  logic [7:0]   tx_data,
    output logic         tx_req,
    output logic [4:0]   tx_slot,
    output logic         dout,
    output logic         dout_oe,
    output logic         rx_valid,
    output logic [7:0]   rx_byte,
    output logic [4:0]   rx_slot
);

    pos_t   cur_pos, nxt_pos;
    logic   cur_lock, nxt_lock, sample_en;
    logic   csel, nsel;
    islot_t cislot, nislot;
    bitn_t  cbit, nbit;

    tdm_frame_timer u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .cfg_rate  (cfg_rate),
        .cfg_dbl   (cfg_dbl),
        .cfg_dly   (cfg_dly),
        .cur_pos   (cur_pos),
        .cur_lock  (cur_lock),
        .sample_en (sample_en),
        .nxt_pos   (nxt_pos),
        .nxt_lock  (nxt_lock)
    );

    tdm_slot_map u_map_cur (
        .pos        (cur_pos),
        .cfg_rate   (cfg_rate),
        .cfg_offset (cfg_offset),
        .sel        (csel),
        .islot      (cislot),
        .bitn       (cbit)
    );

    tdm_slot_map u_map_nxt (
        .pos        (nxt_pos),
        .cfg_rate   (cfg_rate),
        .cfg_offset (cfg_offset),
        .sel        (nsel),
        .islot      (nislot),
        .bitn       (nbit)
    );

    tdm_rx_deser u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_lock  (cur_lock),
        .sample_en (sample_en),
        .csel      (csel),
        .cislot    (cislot),
        .cbit      (cbit),
        .din       (din),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .rx_slot   (rx_slot)
    );

    tdm_tx_ser u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_lock (nxt_lock),
        .nsel     (nsel),
        .nislot   (nislot),
        .nbit     (nbit),
        .tx_data  (tx_data),
        .tx_req   (tx_req),
        .tx_slot  (tx_slot),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    // R8: nothing is driven or received until the first sync edge
    assert_quiet_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_lock |-> (!dout_oe && !rx_valid));

endmodule

// File: tb/tdm_slot_port_tb_top.sv
module tdm_slot_port_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       din = 1'b0;
    logic [1:0] cfg_rate = 2'd0;
    logic [1:0] cfg_offset = 2'd0;
    logic       cfg_dbl = 1'b0;
    logic       cfg_dly = 1'b0;
    logic [7:0] tx_data;
    logic       tx_req;
    logic [4:0] tx_slot;
    logic       dout, dout_oe, rx_valid;
    logic [7:0] rx_byte;
    logic [4:0] rx_slot;
    logic [7:0] seed = 8'h00;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_slot_port dut_i (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .din(din),
        .cfg_rate(cfg_rate), .cfg_offset(cfg_offset), .cfg_dbl(cfg_dbl), .cfg_dly(cfg_dly),
        .tx_data(tx_data), .tx_req(tx_req), .tx_slot(tx_slot),
        .dout(dout), .dout_oe(dout_oe),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_slot(rx_slot)
    );

    function automatic logic [7:0] txpat(input int n);
        return 8'(n * 29 + 3) ^ seed;
    endfunction

    function automatic logic [7:0] rxpat(input int e);
        return 8'(e * 53 + 17) ^ ~seed;
    endfunction

    always_comb tx_data = txpat(int'(tx_slot));

    function automatic int kfac();
        return (cfg_rate == 2'd0) ? 1 : (cfg_rate == 2'd1) ? 2 : 4;
    endfunction

    function automatic int fbits();
        return 256 * kfac();
    endfunction

    function automatic int fcyc();
        return fbits() * (cfg_dbl ? 2 : 1);
    endfunction

    // bit index of a cycle that lies tt cycles after the aligning edge
    function automatic int bpos(input int tt);
        int b;
        b = cfg_dbl ? tt / 2 : tt;
        return ((b - int'(cfg_dly)) % fbits() + fbits()) % fbits();
    endfunction

    function automatic bit is_sample(input int tt);
        return cfg_dbl ? (tt % 2 == 1) : 1'b1;
    endfunction

    function automatic bit selp(input int p);
        int k;
        k = kfac();
        return ((p / 8) % k) == (int'(cfg_offset) & (k - 1));
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // One configuration: reset, lock, run, with optional missing and extra sync pulses
    task automatic run(input logic [1:0] rate, input logic [1:0] off, input bit dbl,
                       input bit dly, input int nframes, input int skip_frame,
                       input int extra_at, input logic [7:0] sd, input string tag);
        int t, tcur, p, e, ncyc, frame_no, rxen;
        bit locked, exp_v, nv, fs_new, fs_prev, edge_s, regular, ex_hit;
        logic [7:0] exp_b, nb, pat;
        int exp_s, ns;
        cfg_rate = rate; cfg_offset = off; cfg_dbl = dbl; cfg_dly = dly; seed = sd;
        rst_n = 1'b0; fsync = 1'b0; din = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state (R8)
        chk({tag, " R8"}, "reset oe", int'(dout_oe), 0);
        chk({tag, " R8"}, "reset rx_valid", int'(rx_valid), 0);
        chk({tag, " R8"}, "reset dout", int'(dout), 0);
        t = 0; locked = 0; exp_v = 0; exp_b = '0; exp_s = 0; rxen = 0;
        fs_prev = 1'b0; frame_no = 0; ex_hit = 0;
        ncyc = 7 + nframes * fcyc();
        for (int j = 0; j < ncyc; j++) begin
            @(negedge clk);
            tcur = t + 1;
            p = bpos(tcur);
            e = p / 8;
            // outputs of this cycle (R5, R8, R3, R4)
            if (locked && selp(p)) begin
                pat = txpat(e / kfac());
                chk({tag, " R5"}, "dout_oe", int'(dout_oe), 1);
                chk({tag, " R5"}, "dout", int'(dout), int'(pat[7 - (p % 8)]));
            end else begin
                chk({tag, locked ? " R5" : " R8"}, "dout_oe idle", int'(dout_oe), 0);
                chk({tag, " R5"}, "dout idle", int'(dout), 0);
            end
            // received byte of previous cycle (R6, R1)
            if (!locked || rxen > fcyc() + 2) begin
                chk({tag, " R6"}, "rx_valid", int'(rx_valid), int'(exp_v));
                if (exp_v && rx_valid) begin
                    chk({tag, " R6"}, "rx_byte", int'(rx_byte), int'(exp_b));
                    chk({tag, " R1"}, "rx_slot", int'(rx_slot), exp_s);
                    if (rate == 2'd2 && off == 2'd2 && rx_slot == 5'd3)
                        chk({tag, " R1 example slot3<-ext14"}, "rx_byte", int'(rx_byte), int'(rxpat(14)));
                end
            end
            // drive din for this cycle from the external slot number
            pat = rxpat(e);
            din = pat[7 - (p % 8)];
            nv = locked && is_sample(tcur) && selp(p) && (p % 8 == 7);
            nb = rxpat(e);
            ns = e / kfac();
            // sync decision for this cycle (R9, R10)
            fs_new = 1'b0;
            if (j == 5) fs_new = 1'b1;
            if (locked && (tcur % fcyc() == 0)) begin
                frame_no++;
                if (frame_no != skip_frame) fs_new = 1'b1;
            end
            if (extra_at > 0 && j == extra_at) begin fs_new = 1'b1; ex_hit = 1; end
            fsync = fs_new;
            edge_s = fs_new && !fs_prev;
            fs_prev = fs_new;
            if (edge_s) begin
                regular = (tcur % fcyc() == 0);
                if (!locked || !regular) rxen = 0;
                locked = 1;
                t = 0;
            end else begin
                t = tcur;
            end
            rxen++;
            exp_v = nv; exp_b = nb; exp_s = ns;
            // transmit request for the next cycle (R7)
            #1;
            p = bpos(t + 1);
            chk({tag, " R7"}, "tx_req", int'(tx_req), int'(locked && selp(p)));
            if (locked && selp(p))
                chk({tag, " R7"}, "tx_slot", int'(tx_slot), (p / 8) / kfac());
        end
        if (extra_at > 0) chk({tag, " R9"}, "extra sync issued", int'(ex_hit), 1);
    endtask

    initial begin
        // x1, offset bits ignored (R2), no delay, single clock (R3)
        run(2'd0, 2'd3, 1'b0, 1'b0, 4, 0, 0, 8'h11, "x1 R2 R3");
        // x2 offset 1, delayed sync (R3), one sync pulse omitted so the counter wraps alone (R10)
        run(2'd1, 2'd1, 1'b0, 1'b1, 5, 2, 0, 8'h5a, "x2 R3 R10");
        // x4 offset 2, doubled clock (R4), example mapping (R1)
        run(2'd2, 2'd2, 1'b1, 1'b0, 3, 0, 0, 8'hc3, "x4 R1 R4");
        // code 3 acts as x4, offset 0, doubled clock with delayed sync (R4 R3)
        run(2'd3, 2'd0, 1'b1, 1'b1, 3, 0, 0, 8'h3c, "x4b R4 R3");
        // x2 with offset bit 1 ignored (R2) and an off-boundary sync edge (R9)
        run(2'd1, 2'd2, 1'b0, 1'b0, 5, 0, 700, 8'h96, "x2 R2 R9");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule